// File: doc/BRIEF.md
# Z80 I/O Port Decoder with Memory-Mode Register and I/O Wait Generator

This block sits beside a Z80 bus, sampled on a local system clock. It watches the I/O request, machine-cycle and read/write lines together with the low address byte. It decodes a 16-port I/O window at 0x60–0x6F into one window strobe and six active-low function strobes. It also holds an 8-bit memory-mode register. Software loads that register by writing to the window. The low five bits of the register drive a bank-select code to the memory steering logic.

Bit 5 of the mode register arms an I/O wait-state generator. When the generator is armed, any I/O access to the high port range 0xE0–0xFF pulls WAITn low. WAITn stays low until an external controller deasserts its active-low bus-request line. The controller therefore has as long as it needs to service the access. Within one bus cycle the wait is raised only once. A status read inside the window returns the mode bits and the current clock-select flag on the data bus. At all other times the block disables its data output.

Top module: `zio_ctrl`

## Requirements
- R1: `io_win_n` is low only while `iorq_n` is low, `m1_n` is high and `bus_addr[7:4]` = 4'b0110. Address bits [15:8] have no effect. Outside the window every strobe stays high.
- R2: Inside the window, `bus_addr[3:1]` picks one function strobe:
  - 0 (0x60/61) gives `mode_wr_n`, which also needs `wr_n` low.
  - 1 (0x62/63) gives `clk_alt_n`, which also needs `wr_n` low.
  - 2 (0x64/65) gives `clk_base_n`, which also needs `wr_n` low.
  - 3 (0x66/67) gives `stat_rd_n`, which also needs `rd_n` low.
  - 4 (0x68/69) gives `svc_req_n` on any access.
  - 5 (0x6A/6B) gives `sys_req_n` on any access.
  - 6 and 7 raise only the window strobe.

  At most one function strobe is low at a time.
- R3: After reset the following hold:
  - The mode register is 0 and `mem_bank` is 0.
  - The clock-select flag is 0.
  - `wait_n` is high.
  - `bus_data_oe` is low.
- R4: At each rising clock edge while `mode_wr_n` is low, the mode register loads `bus_data_i`. At no other time does it change. In particular, writes to other ports or with `m1_n` low leave it alone.
- R5: `mem_bank` always equals mode register bits [4:0]. It shows a load at the clock edge that performs the load.
- R6: Suppose mode bit 5 is 1 and an I/O access is in progress (`iorq_n` low, `m1_n` high) to an address with `bus_addr[7:5]` = 3'b111. Then `wait_n` goes low at the first rising edge of that access. With bit 5 at 0, at address 0xDF, or with `m1_n` low, `wait_n` stays high.
- R7: Once low, `wait_n` stays low at every edge where `ctl_rel_n` is low. It returns high at the first rising edge that samples `ctl_rel_n` high.
- R8: After a release, `wait_n` stays high for the rest of the same bus cycle. Once `iorq_n` has been high at one edge, a new qualifying access raises the wait again.
- R9: During a read of 0x66/0x67, `bus_data_oe` is 1 and `bus_data_o` = {clock-select flag, mode[6:0]}. At all other times `bus_data_oe` is 0 and `bus_data_o` is 0.
- R10: A write to 0x62/0x63 sets the clock-select flag to 1. A write to 0x64/0x65 clears it. The flag is seen through bit 7 of the R9 status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 16 | Z80 address bus |
| bus_data_i | input | 8 | Z80 data bus, as seen by the block |
| bus_data_o | output | 8 | Status word driven during a status read |
| bus_data_oe | output | 1 | Output enable for `bus_data_o` |
| iorq_n | input | 1 | I/O request, active low |
| m1_n | input | 1 | Opcode fetch / interrupt acknowledge, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ctl_rel_n | input | 1 | Controller bus request, active low; high releases the wait |
| io_win_n | output | 1 | Window 0x60–0x6F selected |
| mode_wr_n | output | 1 | Mode register write strobe |
| clk_alt_n | output | 1 | Alternate clock request strobe |
| clk_base_n | output | 1 | Base clock request strobe |
| stat_rd_n | output | 1 | Status read strobe |
| svc_req_n | output | 1 | Service request strobe |
| sys_req_n | output | 1 | System request strobe |
| mem_bank | output | 5 | Memory-mode bank code |
| wait_n | output | 1 | Wait request to the CPU, active low |

## Verification
A corrupted mode register shows on `mem_bank` at the next sample after the bad edge. The same fault appears in the status word on the next read of 0x66. A wait latch stuck high or low shows on `wait_n` within one clock of the qualifying access or of the release. A lost "served" flag reappears as a second low pulse on `wait_n` one clock after a release while `iorq_n` is still low. Decode faults are visible in the same cycle, because every strobe is combinational from the bus lines.

// File: rtl/zio_pkg.sv
package zio_pkg;

  // Function group index taken from address bits [3:1] inside the window
  localparam int GRP_MODE   = 0;
  localparam int GRP_CLKALT = 1;
  localparam int GRP_CLKBAS = 2;
  localparam int GRP_STATUS = 3;
  localparam int GRP_SVC    = 4;
  localparam int GRP_SYS    = 5;
  localparam int GRP_COUNT  = 8;

  // Internal strobe bundle, active high
  typedef struct packed {
    logic win;
    logic mode_wr;
    logic clk_alt;
    logic clk_base;
    logic stat_rd;
    logic svc;
    logic sys;
  } strobe_t;

endpackage

// File: rtl/zio_port_decode.sv
module zio_port_decode
  import zio_pkg::*;
#(
  parameter int              PORT_W  = 8,
  parameter logic [3:0]      WIN_NIB = 4'h6,
  parameter int              HI_W    = 3,
  parameter logic [HI_W-1:0] HI_TAG  = '1
) (
  input  logic [PORT_W-1:0] port,
  input  logic              iorq_n,
  input  logic              m1_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output strobe_t           stb,
  output logic              hi_hit
);

  localparam int SEL_W = $clog2(GRP_COUNT);

  logic                 io_cyc;
  logic                 win;
  logic [GRP_COUNT-1:0] grp;

  // A genuine I/O cycle: request low and not an interrupt acknowledge
  assign io_cyc = !iorq_n && m1_n;
  assign win    = io_cyc && (port[PORT_W-1 -: 4] == WIN_NIB);

  // One group select per pair of ports
  generate
    for (genvar g = 0; g < GRP_COUNT; g++) begin : g_grp
      assign grp[g] = win && (port[SEL_W:1] == SEL_W'(g));
    end
  endgenerate

  logic unused_grp;
  assign unused_grp = ^grp[GRP_COUNT-1:GRP_SYS+1];

  always_comb begin
    stb          = '0;
    stb.win      = win;
    stb.mode_wr  = grp[GRP_MODE]   && !wr_n;
    stb.clk_alt  = grp[GRP_CLKALT] && !wr_n;
    stb.clk_base = grp[GRP_CLKBAS] && !wr_n;
    stb.stat_rd  = grp[GRP_STATUS] && !rd_n;
    stb.svc      = grp[GRP_SVC];
    stb.sys      = grp[GRP_SYS];
  end

  assign hi_hit = io_cyc && (port[PORT_W-1 -: HI_W] == HI_TAG);

endmodule

// File: rtl/zio_mode_reg.sv
module zio_mode_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data_i,
  input  logic              alt_req,
  input  logic              base_req,
  output logic [DATA_W-1:0] mode_q,
  output logic              clk_sel_q
);

  logic [DATA_W-1:0] mode_d;
  logic              mode_en;
  logic              sel_d;
  logic              sel_en;

  // Next-state logic
  always_comb begin
    mode_en = load;
    mode_d  = data_i;
    sel_en  = alt_req || base_req;
    sel_d   = alt_req;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      clk_sel_q <= 1'b0;
    end else begin
      if (mode_en) mode_q    <= mode_d;
      if (sel_en)  clk_sel_q <= sel_d;
    end
  end

endmodule

// File: rtl/zio_wait_gen.sv
module zio_wait_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic hit,
  input  logic iorq_n,
  input  logic rel_n,
  output logic wait_q
);

  logic served_q;
  logic served_d;
  logic wait_d;
  logic set_c;
  logic clr_c;

  // Set/reset latch with a once-per-bus-cycle guard
  always_comb begin
    set_c    = enable && hit && !served_q && !wait_q;
    clr_c    = wait_q && rel_n;
    wait_d   = wait_q;
    if (set_c)      wait_d = 1'b1;
    else if (clr_c) wait_d = 1'b0;
    served_d = served_q;
    if (iorq_n)     served_d = 1'b0;
    else if (set_c) served_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q   <= 1'b0;
      served_q <= 1'b0;
    end else begin
      wait_q   <= wait_d;
      served_q <= served_d;
    end
  end

endmodule

// File: rtl/zio_ctrl.sv
module zio_ctrl
  import zio_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PORT_W   = 8,
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 5,
  parameter int WAIT_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe,
  input  logic              iorq_n,
  input  logic              m1_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              ctl_rel_n,
  output logic              io_win_n,
  output logic              mode_wr_n,
  output logic              clk_alt_n,
  output logic              clk_base_n,
  output logic              stat_rd_n,
  output logic              svc_req_n,
  output logic              sys_req_n,
  output logic [BANK_W-1:0] mem_bank,
  output logic              wait_n
);

  localparam int RST_STAGES = 2;

  // Reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  logic unused_addr;
  assign unused_addr = ^bus_addr[ADDR_W-1:PORT_W];

  strobe_t           stb;
  logic              hi_hit;
  logic [DATA_W-1:0] mode_q;
  logic              clk_sel_q;
  logic              wait_q;

  zio_port_decode #(
    .PORT_W (PORT_W)
  ) u_dec (
    .port   (bus_addr[PORT_W-1:0]),
    .iorq_n (iorq_n),
    .m1_n   (m1_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .stb    (stb),
    .hi_hit (hi_hit)
  );

  zio_mode_reg #(
    .DATA_W (DATA_W)
  ) u_mode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (stb.mode_wr),
    .data_i    (bus_data_i),
    .alt_req   (stb.clk_alt),
    .base_req  (stb.clk_base),
    .mode_q    (mode_q),
    .clk_sel_q (clk_sel_q)
  );

  zio_wait_gen u_wait (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .enable (mode_q[WAIT_BIT]),
    .hit    (hi_hit),
    .iorq_n (iorq_n),
    .rel_n  (ctl_rel_n),
    .wait_q (wait_q)
  );

  // Active-low strobe outputs
  assign io_win_n   = !stb.win;
  assign mode_wr_n  = !stb.mode_wr;
  assign clk_alt_n  = !stb.clk_alt;
  assign clk_base_n = !stb.clk_base;
  assign stat_rd_n  = !stb.stat_rd;
  assign svc_req_n  = !stb.svc;
  assign sys_req_n  = !stb.sys;

  assign mem_bank   = mode_q[BANK_W-1:0];
  assign wait_n     = !wait_q;

  // Status word: clock-select flag on top, mode bits below
  assign bus_data_oe = stb.stat_rd;
  assign bus_data_o  = stb.stat_rd ? {clk_sel_q, mode_q[DATA_W-2:0]} : '0;

endmodule

// File: rtl/zio_ctrl_chk.sv
module zio_ctrl_chk #(
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 5,
  parameter int WAIT_BIT = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iorq_n,
  input logic              m1_n,
  input logic              rd_n,
  input logic              ctl_rel_n,
  input logic              io_win_n,
  input logic              mode_wr_n,
  input logic              clk_alt_n,
  input logic              clk_base_n,
  input logic              stat_rd_n,
  input logic              svc_req_n,
  input logic              sys_req_n,
  input logic [BANK_W-1:0] mem_bank,
  input logic              wait_n,
  input logic              bus_data_oe,
  input logic [DATA_W-1:0] mode_q
);

  AST_WIN_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !io_win_n |-> (!iorq_n && m1_n)) else $error("window outside I/O cycle"); // R1

  AST_SUB_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_wr_n || !clk_alt_n || !clk_base_n || !stat_rd_n || !svc_req_n || !sys_req_n)
      |-> !io_win_n) else $error("function strobe without window"); // R2

  AST_ONE_FUNCTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!mode_wr_n, !clk_alt_n, !clk_base_n, !stat_rd_n, !svc_req_n, !sys_req_n}))
    else $error("several function strobes"); // R2

  AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_n |=> $stable(mem_bank)) else $error("bank changed without write"); // R4

  AST_WAIT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_n) |-> $past(mode_q[WAIT_BIT] && !iorq_n && m1_n))
    else $error("wait raised while disarmed"); // R6

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_n && !ctl_rel_n) |=> !wait_n) else $error("wait dropped early"); // R7

  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wait_n && ctl_rel_n) |=> wait_n) else $error("wait not released"); // R7

  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wait_n) && !iorq_n) |=> wait_n) else $error("wait retriggered"); // R8

  AST_OE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> (!rd_n && !stat_rd_n)) else $error("data driven outside read"); // R9

endmodule

bind zio_ctrl zio_ctrl_chk #(
  .DATA_W   (DATA_W),
  .BANK_W   (BANK_W),
  .WAIT_BIT (WAIT_BIT)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .iorq_n      (iorq_n),
  .m1_n        (m1_n),
  .rd_n        (rd_n),
  .ctl_rel_n   (ctl_rel_n),
  .io_win_n    (io_win_n),
  .mode_wr_n   (mode_wr_n),
  .clk_alt_n   (clk_alt_n),
  .clk_base_n  (clk_base_n),
  .stat_rd_n   (stat_rd_n),
  .svc_req_n   (svc_req_n),
  .sys_req_n   (sys_req_n),
  .mem_bank    (mem_bank),
  .wait_n      (wait_n),
  .bus_data_oe (bus_data_oe),
  .mode_q      (mode_q)
);

// File: tb/zio_ctrl_tb_top.sv
module zio_ctrl_tb_top;

  localparam time CLK_PERIOD = 10;
  localparam int  K_STB  = 0;
  localparam int  K_BANK = 1;
  localparam int  K_WAIT = 2;
  localparam int  K_OE   = 3;
  localparam int  K_DOUT = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_data_i;
  logic [7:0]  bus_data_o;
  logic        bus_data_oe;
  logic        iorq_n, m1_n, rd_n, wr_n, ctl_rel_n;
  logic        io_win_n, mode_wr_n, clk_alt_n, clk_base_n;
  logic        stat_rd_n, svc_req_n, sys_req_n;
  logic [4:0]  mem_bank;
  logic        wait_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  zio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data_i(bus_data_i),
    .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe), .iorq_n(iorq_n),
    .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n), .ctl_rel_n(ctl_rel_n),
    .io_win_n(io_win_n), .mode_wr_n(mode_wr_n), .clk_alt_n(clk_alt_n),
    .clk_base_n(clk_base_n), .stat_rd_n(stat_rd_n), .svc_req_n(svc_req_n),
    .sys_req_n(sys_req_n), .mem_bank(mem_bank), .wait_n(wait_n)
  );

  typedef struct {
    string       req;
    int          kind;
    logic [15:0] exp;
  } exp_t;

  exp_t sbq[$];
  event chk_ev;
  int   checks   = 0;
  int   failures = 0;
  bit   done     = 1'b0;
  logic [7:0] m_mode = 8'h00;
  logic       m_sel  = 1'b0;

  function automatic logic [15:0] observe(int kind);
    case (kind)
      K_STB:   return {9'd0, io_win_n, mode_wr_n, clk_alt_n, clk_base_n,
                       stat_rd_n, svc_req_n, sys_req_n};
      K_BANK:  return {11'd0, mem_bank};
      K_WAIT:  return {15'd0, wait_n};
      K_OE:    return {15'd0, bus_data_oe};
      default: return {8'd0, bus_data_o};
    endcase
  endfunction

  // Monitor: pops expected items and compares with the ports
  always begin
    @(chk_ev);
    while (sbq.size() > 0) begin
      exp_t        e;
      logic [15:0] a;
      e = sbq.pop_front();
      a = observe(e.kind);
      checks++;
      if (a !== e.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", e.req, e.kind, a, e.exp);
      end
    end
  end

  task automatic push(string r, int k, logic [15:0] v);
    exp_t e;
    e.req = r; e.kind = k; e.exp = v;
    sbq.push_back(e);
  endtask

  task automatic settle();
    -> chk_ev;
    #1;
  endtask

  function automatic logic [6:0] exp_stb(logic [7:0] p, logic io_n, logic m1, logic rd, logic wr);
    logic [6:0] s;
    s = 7'h7F;
    if (!io_n && m1 && p[7:4] == 4'h6) begin
      s[6] = 1'b0;
      case (p[3:1])
        3'd0: s[5] = wr;
        3'd1: s[4] = wr;
        3'd2: s[3] = wr;
        3'd3: s[2] = rd;
        3'd4: s[1] = 1'b0;
        3'd5: s[0] = 1'b0;
        default: ;
      endcase
    end
    return s;
  endfunction

  task automatic bus_idle();
    iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
  endtask

  // Start an access at a falling edge; strobes settle at once
  task automatic io_start(logic [15:0] a, logic rd, logic wr, logic m1, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_data_i = d; rd_n = rd; wr_n = wr; m1_n = m1; iorq_n = 1'b0;
    #1;
  endtask

  task automatic io_end();
    @(negedge clk);
    bus_idle();
    #1;
  endtask

  // Complete write, updating the bench model by the requirements
  task automatic io_write(logic [15:0] a, logic [7:0] d, logic m1, string r);
    io_start(a, 1'b1, 1'b0, m1, d);
    push(r, K_STB, {9'd0, exp_stb(a[7:0], 1'b0, m1, 1'b1, 1'b0)});
    settle();
    if (m1 && a[7:4] == 4'h6) begin
      if (a[3:1] == 3'd0) m_mode = d;
      if (a[3:1] == 3'd1) m_sel = 1'b1;
      if (a[3:1] == 3'd2) m_sel = 1'b0;
    end
    io_end();
  endtask

  task automatic status_read(logic [7:0] p, string r);
    io_start({8'h00, p}, 1'b0, 1'b1, 1'b1, 8'h00);
    push(r, K_STB, {9'd0, exp_stb(p, 1'b0, 1'b1, 1'b0, 1'b1)});
    if (p[7:1] == 7'h33) begin
      push(r, K_OE, 16'd1);
      push(r, K_DOUT, {8'd0, m_sel, m_mode[6:0]});
    end else begin
      push(r, K_OE, 16'd0);
      push(r, K_DOUT, 16'd0);
    end
    settle();
    io_end();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = 16'h0000; bus_data_i = 8'h00; ctl_rel_n = 1'b1;
    bus_idle();
    repeat (3) @(negedge clk);
    #1;
    // R3 reset state while held in reset
    push("R3", K_STB, 16'h007F);
    push("R3", K_BANK, 16'd0);
    push("R3", K_WAIT, 16'd1);
    push("R3", K_OE, 16'd0);
    settle();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    push("R3", K_BANK, 16'd0);
    push("R3", K_WAIT, 16'd1);
    settle();
    status_read(8'h66, "R3");

    // R2: every port of the window, writes then reads
    for (int p = 8'h60; p <= 8'h6F; p++) io_write({8'h00, 8'(p)}, 8'h00, 1'b1, "R2");
    for (int p = 8'h60; p <= 8'h6F; p++) status_read(8'(p), "R2_R9");

    // R1 qualification
    io_start(16'h0068, 1'b0, 1'b1, 1'b0, 8'h00);
    push("R1", K_STB, 16'h007F); settle(); io_end();
    @(negedge clk); bus_addr = 16'h0069; rd_n = 1'b0; #1;
    push("R1", K_STB, 16'h007F); settle(); io_end();
    io_start(16'h0070, 1'b0, 1'b1, 1'b1, 8'h00);
    push("R1", K_STB, 16'h007F); settle(); io_end();
    io_start(16'h005F, 1'b0, 1'b1, 1'b1, 8'h00);
    push("R1", K_STB, 16'h007F); settle(); io_end();
    io_start(16'hAB69, 1'b0, 1'b1, 1'b1, 8'h00);
    push("R1", K_STB, {9'd0, exp_stb(8'h69, 1'b0, 1'b1, 1'b0, 1'b1)}); settle(); io_end();

    // R4 / R5 mode register loads
    io_write(16'h0060, 8'hA5, 1'b1, "R4");
    push("R5", K_BANK, {11'd0, m_mode[4:0]}); settle();
    status_read(8'h66, "R4_R9");
    io_write(16'h0061, 8'h13, 1'b1, "R4");
    push("R5", K_BANK, 16'h0013); settle();
    io_write(16'h006A, 8'hFF, 1'b1, "R4");
    push("R4", K_BANK, 16'h0013); settle();
    io_write(16'h0060, 8'h1F, 1'b0, "R4");
    push("R4", K_BANK, 16'h0013); settle();
    status_read(8'h67, "R4");

    // R10 clock-select flag
    io_write(16'h0063, 8'h00, 1'b1, "R10");
    status_read(8'h66, "R10");
    io_write(16'h0065, 8'h00, 1'b1, "R10");
    status_read(8'h67, "R10");

    // R6 wait disarmed while mode bit 5 is 0
    ctl_rel_n = 1'b0;
    io_start(16'h00E0, 1'b0, 1'b1, 1'b1, 8'h00);
    push("R6", K_STB, 16'h007F); settle();
    repeat (2) @(negedge clk); #1;
    push("R6", K_WAIT, 16'd1); settle();
    io_end();

    // Arm the generator
    io_write(16'h0060, 8'h25, 1'b1, "R4");
    push("R5", K_BANK, 16'h0005); settle();

    // R6 / R7 / R8 held wait with handshake release
    io_start(16'h00E0, 1'b0, 1'b1, 1'b1, 8'h00);
    push("R6", K_WAIT, 16'd1); settle();
    @(negedge clk); #1;
    push("R6", K_WAIT, 16'd0); settle();
    repeat (3) @(negedge clk); #1;
    push("R7", K_WAIT, 16'd0); settle();
    ctl_rel_n = 1'b1;
    @(negedge clk); #1;
    push("R7", K_WAIT, 16'd1); settle();
    repeat (2) @(negedge clk); #1;
    push("R8", K_WAIT, 16'd1); settle();
    io_end();

    // R8 re-arm on a new bus cycle, boundary 0xFF, immediate release
    io_start(16'h00FF, 1'b1, 1'b0, 1'b1, 8'h00);
    @(negedge clk); #1;
    push("R8", K_WAIT, 16'd0); settle();
    @(negedge clk); #1;
    push("R7", K_WAIT, 16'd1); settle();
    io_end();

    // R6 boundaries: 0xDF and interrupt acknowledge
    ctl_rel_n = 1'b0;
    io_start(16'h00DF, 1'b0, 1'b1, 1'b1, 8'h00);
    repeat (2) @(negedge clk); #1;
    push("R6", K_WAIT, 16'd1); settle();
    io_end();
    io_start(16'h00F0, 1'b1, 1'b1, 1'b0, 8'h00);
    repeat (2) @(negedge clk); #1;
    push("R6", K_WAIT, 16'd1); settle();
    io_end();

    // R7 write access held, then released
    io_start(16'h12E5, 1'b1, 1'b0, 1'b1, 8'h5A);
    repeat (2) @(negedge clk); #1;
    push("R7", K_WAIT, 16'd0);
    push("R5", K_BANK, 16'h0005); settle();
    ctl_rel_n = 1'b1;
    @(negedge clk); #1;
    push("R7", K_WAIT, 16'd1); settle();
    io_end();
    status_read(8'h66, "R9");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule